// File: doc/BRIEF.md
# Run-Time Selectable Serial CRC Engine

This block computes and verifies cyclic redundancy check sequences one bit per clock. A single shift register with XOR feedback acts as a modulo-2 divider. It works in two modes. When generating, it takes a message, most significant bit first, and then emits the remainder so that the remainder can be appended to the message. When checking, it takes a received frame (message followed by its check sequence) and reports whether the division leaves a nonzero remainder.

The generator polynomial is chosen at the start of each frame from a small fixed set. The set holds a 5-bit test polynomial and four widely used polynomials of degree 12, 16, 16 and 32. The part of the register in use is exactly as wide as the degree of the chosen polynomial. The register starts from zero. Bits are never reflected, and no value is XORed onto the result.

Top module: `crc_serial_engine`

## Requirements
- R1: `poly_sel` picks the divisor: 0 = x^5+x^4+x^2+1, 1 = x^12+x^11+x^3+x^2+x+1, 2 = x^16+x^15+x^2+1, 3 = x^16+x^12+x^5+1, 4 = the degree-32 polynomial with terms 32,26,23,22,16,12,11,10,8,7,5,4,2,1,0. Codes 5 to 7 act as code 0. The remainder has as many bits as the degree, and register bits above the degree stay zero.
- R2: A one-cycle `sof` pulse clears the remainder and opens a frame. A `bit_valid` in the same cycle as `sof` is not consumed.
- R3: In generate mode (`mode_sel`=0), `data_end` marks the last message bit, given together with `bit_valid`. On the clock cycles that follow it, `fcs_valid` is high for exactly degree-many cycles. During those cycles `fcs_bit` carries the remainder, most significant bit first.
- R4: `done` is high for exactly one cycle: the cycle after the last check-sequence bit.
- R5: The emitted sequence equals the modulo-2 remainder of the message multiplied by x^degree, divided by the selected polynomial.
- R6: In check mode (`mode_sel`=1), `data_end` marks the last bit of the whole received frame. On the next cycle `err_valid` is high for one cycle, and `crc_err` is 1 exactly when the remainder is nonzero.
- R7: Bits, `bit_valid` and `data_end` have no effect while no frame is open and while the check sequence is being shifted out.
- R8: Changes to `poly_sel` or `mode_sel` after `sof` do not affect the current frame.
- R9: After reset, `fcs_valid`, `fcs_bit`, `done`, `err_valid` and `crc_err` are all 0.
- R10: A `sof` pulse in the middle of a frame drops that frame and starts a new one from a cleared register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; latches mode and polynomial |
| mode_sel | input | 1 | 0 = generate, 1 = check |
| poly_sel | input | 3 | Polynomial code (see R1) |
| bit_valid | input | 1 | `bit_in` is to be consumed this cycle |
| bit_in | input | 1 | Serial data bit |
| data_end | input | 1 | With `bit_valid`, marks the last input bit |
| fcs_bit | output | 1 | Serial check-sequence bit |
| fcs_valid | output | 1 | `fcs_bit` is meaningful |
| done | output | 1 | One-cycle pulse after the final check bit |
| err_valid | output | 1 | One-cycle pulse carrying the check result |
| crc_err | output | 1 | Nonzero remainder in check mode |

## Verification
Every result is registered once after the edge that causes it. The bench drives inputs on the falling edge and samples outputs on later falling edges.

- The first check-sequence bit is sampled on the falling edge right after the edge that takes the last message bit. Each later bit is sampled one cycle further on.
- `done` is sampled degree+1 falling edges after that last bit.
- `err_valid` and `crc_err` are sampled on the first falling edge after the last frame bit, and `err_valid` is sampled again one cycle later to confirm it has dropped.

Expected remainders come from a long-division model in the bench. One string of known content, run through the degree-16 polynomial with terms 16,12,5,0, is also compared against its published value.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_FCS  = 2'd2
   } crc_state_e;

   localparam logic MODE_GEN   = 1'b0;
   localparam logic MODE_CHECK = 1'b1;

   localparam int MIN_REG_W = 32;

   // Feedback taps (divisor without its leading term), MSB-first form.
   function automatic logic [31:0] crc_taps(input logic [2:0] code);
      case (code)
         3'd1:    crc_taps = 32'h0000_080F;
         3'd2:    crc_taps = 32'h0000_8005;
         3'd3:    crc_taps = 32'h0000_1021;
         3'd4:    crc_taps = 32'h04C1_1DB7;
         default: crc_taps = 32'h0000_0015;
      endcase
   endfunction

   function automatic int unsigned crc_degree(input logic [2:0] code);
      case (code)
         3'd1:    crc_degree = 12;
         3'd2:    crc_degree = 16;
         3'd3:    crc_degree = 16;
         3'd4:    crc_degree = 32;
         default: crc_degree = 5;
      endcase
   endfunction

endpackage

// File: rtl/crc_poly_table.sv
module crc_poly_table
   import crc_serial_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int SEL_W = 3,
   localparam int DEG_W = $clog2(REG_W + 1)
) (
   input  logic [SEL_W-1:0] sel,
   output logic [REG_W-1:0] taps,
   output logic [REG_W-1:0] mask,
   output logic [REG_W-1:0] top,
   output logic [DEG_W-1:0] deg
);

   if (REG_W < MIN_REG_W) begin : g_bad_width
      $error("crc_poly_table: REG_W must hold the widest divisor");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("crc_poly_table: SEL_W must be 3");
   end

   assign taps = REG_W'(crc_taps(sel));
   assign deg  = DEG_W'(crc_degree(sel));

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      assign mask[i] = (DEG_W'(i) < deg);
      assign top[i]  = (DEG_W'(i + 1) == deg);
   end

endmodule

// File: rtl/crc_div_reg.sv
module crc_div_reg #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             shift,
   input  logic             din,
   input  logic [REG_W-1:0] taps,
   input  logic [REG_W-1:0] mask,
   input  logic [REG_W-1:0] top,
   output logic [REG_W-1:0] rem,
   output logic             msb
);

   logic [REG_W-1:0] rem_q;
   logic [REG_W-1:0] rem_d;
   logic             fb;

   assign msb = |(rem_q & top);
   assign fb  = msb ^ din;

   for (genvar i = 0; i < REG_W; i++) begin : g_cell
      logic below;
      if (i == 0) begin : g_lsb
         assign below = 1'b0;
      end else begin : g_upper
         assign below = rem_q[i-1];
      end

      always_comb begin
         if (clr) begin
            rem_d[i] = 1'b0;
         end else if (step) begin
            rem_d[i] = (below & mask[i]) ^ (fb & taps[i]);
         end else if (shift) begin
            rem_d[i] = below & mask[i];
         end else begin
            rem_d[i] = rem_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else begin
         rem_q <= rem_d;
      end
   end

   assign rem = rem_q;

   // R1: bits above the active degree never become set
   p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q & ~mask) == '0);

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
   import crc_serial_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int SEL_W = 3,
   localparam int DEG_W = $clog2(REG_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             bit_valid,
   input  logic             data_end,
   input  logic             mode_sel,
   input  logic [SEL_W-1:0] poly_sel,
   input  logic [DEG_W-1:0] deg,
   output logic [SEL_W-1:0] sel_q,
   output logic             clr,
   output logic             step,
   output logic             shift,
   output logic             in_frame,
   output logic             fcs_valid,
   output logic             done,
   output logic             err_valid
);

   crc_state_e       state;
   logic             mode_q;
   logic [DEG_W-1:0] cnt;
   logic             last_in;

   assign last_in = bit_valid && data_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode_q    <= MODE_GEN;
         sel_q     <= '0;
         cnt       <= '0;
         done      <= 1'b0;
         err_valid <= 1'b0;
      end else begin
         done      <= 1'b0;
         err_valid <= 1'b0;
         if (sof) begin
            state  <= ST_DATA;
            mode_q <= mode_sel;
            sel_q  <= poly_sel;
            cnt    <= '0;
         end else begin
            case (state)
               ST_DATA: begin
                  if (last_in) begin
                     if (mode_q == MODE_CHECK) begin
                        state     <= ST_IDLE;
                        err_valid <= 1'b1;
                     end else begin
                        state <= ST_FCS;
                        cnt   <= '0;
                     end
                  end
               end
               ST_FCS: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == DEG_W'(deg - 1'b1)) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign clr       = sof;
   assign step      = !sof && (state == ST_DATA) && bit_valid;
   assign shift     = !sof && (state == ST_FCS);
   assign in_frame  = (state != ST_IDLE);
   assign fcs_valid = (state == ST_FCS);

   // R3: shifting never runs past the active degree
   p_fcs_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fcs_valid |-> (cnt < deg));
   // R4: completion is a single-cycle pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: completion only follows a shifting cycle
   p_done_after_fcs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fcs_valid));
   // R6: result strobe lasts one cycle
   p_errv_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> !err_valid);

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
   parameter int REG_W = 32,
   parameter int SEL_W = 3,
   localparam int DEG_W = $clog2(REG_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             mode_sel,
   input  logic [SEL_W-1:0] poly_sel,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic             data_end,
   output logic             fcs_bit,
   output logic             fcs_valid,
   output logic             done,
   output logic             err_valid,
   output logic             crc_err
);

   logic [SEL_W-1:0] sel_q;
   logic [REG_W-1:0] taps;
   logic [REG_W-1:0] mask;
   logic [REG_W-1:0] top;
   logic [DEG_W-1:0] deg;
   logic [REG_W-1:0] rem;
   logic             msb;
   logic             clr;
   logic             step;
   logic             shift;
   logic             in_frame;

   crc_poly_table #(.REG_W(REG_W), .SEL_W(SEL_W)) u_table (
      .sel  (sel_q),
      .taps (taps),
      .mask (mask),
      .top  (top),
      .deg  (deg)
   );

   crc_seq_ctrl #(.REG_W(REG_W), .SEL_W(SEL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (sof),
      .bit_valid (bit_valid),
      .data_end  (data_end),
      .mode_sel  (mode_sel),
      .poly_sel  (poly_sel),
      .deg       (deg),
      .sel_q     (sel_q),
      .clr       (clr),
      .step      (step),
      .shift     (shift),
      .in_frame  (in_frame),
      .fcs_valid (fcs_valid),
      .done      (done),
      .err_valid (err_valid)
   );

   crc_div_reg #(.REG_W(REG_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (step),
      .shift (shift),
      .din   (bit_in),
      .taps  (taps),
      .mask  (mask),
      .top   (top),
      .rem   (rem),
      .msb   (msb)
   );

   assign fcs_bit = fcs_valid & msb;
   assign crc_err = err_valid & (|rem);

   // R7: with no open frame the remainder cannot move
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !sof) |=> $stable(rem));
   // R5: once every check bit has left, the divider is empty
   p_done_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem == '0));
   // R3: emitting and reporting never coincide
   p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fcs_valid && err_valid));

endmodule

// File: tb/crc_serial_engine_tb.sv
`timescale 1ns/1ps
module crc_serial_engine_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof = 1'b0;
   logic       mode_sel = 1'b0;
   logic [2:0] poly_sel = 3'd0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic       data_end = 1'b0;
   logic       fcs_bit;
   logic       fcs_valid;
   logic       done;
   logic       err_valid;
   logic       crc_err;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   crc_serial_engine u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (sof),
      .mode_sel  (mode_sel),
      .poly_sel  (poly_sel),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .data_end  (data_end),
      .fcs_bit   (fcs_bit),
      .fcs_valid (fcs_valid),
      .done      (done),
      .err_valid (err_valid),
      .crc_err   (crc_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int deg_of(input logic [2:0] code);
      case (code)
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 16;
         3'd4: return 32;
         default: return 5;
      endcase
   endfunction

   function automatic logic [32:0] divisor_of(input logic [2:0] code);
      case (code)
         3'd1: return 33'h0_0000_180F;
         3'd2: return 33'h0_0001_8005;
         3'd3: return 33'h0_0001_1021;
         3'd4: return 33'h1_04C1_1DB7;
         default: return 33'h0_0000_0035;
      endcase
   endfunction

   // Long division of the message followed by d zero bits.
   function automatic logic [31:0] ref_rem(input logic [2:0] code,
                                           input logic [127:0] msg, input int len);
      logic [33:0] acc;
      logic [32:0] dv;
      int          d;
      d   = deg_of(code);
      dv  = divisor_of(code);
      acc = '0;
      for (int i = len + d - 1; i >= 0; i--) begin
         logic b;
         b   = (i >= d) ? msg[i-d] : 1'b0;
         acc = {acc[32:0], b};
         if (acc[d]) acc = acc ^ {1'b0, dv};
      end
      for (int i = 32; i < 34; i++) acc[i] = 1'b0;
      return acc[31:0];
   endfunction

   task automatic idle_inputs();
      sof = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; data_end = 1'b0;
   endtask

   task automatic open_frame(input logic [2:0] code, input logic md, input bit junk);
      @(negedge clk);
      sof = 1'b1; poly_sel = code; mode_sel = md;
      bit_valid = junk; bit_in = junk; data_end = 1'b0;
   endtask

   task automatic feed(input logic [159:0] v, input int n, input bit alter_sel);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         sof = 1'b0; bit_valid = 1'b1; bit_in = v[i]; data_end = (i == 0);
         if (alter_sel && i == n - 2) begin
            poly_sel = poly_sel + 3'd3;
            mode_sel = ~mode_sel;
         end
      end
   endtask

   task automatic run_gen(input logic [2:0] code, input logic [127:0] msg, input int len,
                          input bit junk, input bit alter_sel, input bit disturb,
                          input string req, output logic [31:0] got);
      int          d;
      logic [31:0] exp;
      bit          vld_ok;
      d = deg_of(code);
      exp = ref_rem(code, msg, len);
      got = '0;
      vld_ok = 1'b1;
      open_frame(code, 1'b0, junk);
      feed({32'h0, msg}, len, alter_sel);
      for (int j = 0; j < d; j++) begin
         @(negedge clk);
         if (fcs_valid !== 1'b1) vld_ok = 1'b0;
         got = {got[30:0], fcs_bit};
         idle_inputs();
         if (disturb) begin
            bit_valid = 1'b1; bit_in = j[0]; data_end = 1'b1;
         end
      end
      @(negedge clk);
      chk(vld_ok, "R3", {req, " fcs_valid held for degree cycles"}, 64'(vld_ok), 64'd1);
      chk(got == exp, "R5", {req, " check sequence value"}, 64'(got), 64'(exp));
      chk(done === 1'b1 && fcs_valid === 1'b0, "R4", {req, " done after last bit"},
          64'({done, fcs_valid}), 64'b10);
      idle_inputs();
      @(negedge clk);
      chk(done === 1'b0, "R4", {req, " done lasts one cycle"}, 64'(done), 64'd0);
   endtask

   task automatic run_chk(input logic [2:0] code, input logic [127:0] msg, input int len,
                          input logic [159:0] flip, input string req);
      int           d;
      logic [159:0] frame;
      logic         exp_err;
      d = deg_of(code);
      frame = ({32'h0, msg} << d) | 160'(ref_rem(code, msg, len));
      frame = frame ^ flip;
      exp_err = (flip != '0);
      open_frame(code, 1'b1, 1'b0);
      feed(frame, len + d, 1'b0);
      @(negedge clk);
      idle_inputs();
      chk(err_valid === 1'b1 && crc_err === exp_err, "R6", {req, " result strobe"},
          64'({err_valid, crc_err}), 64'({1'b1, exp_err}));
      @(negedge clk);
      chk(err_valid === 1'b0 && crc_err === 1'b0, "R6", {req, " strobe drops"},
          64'({err_valid, crc_err}), 64'd0);
   endtask

   task automatic t_reset();
      chk(fcs_valid === 1'b0 && fcs_bit === 1'b0, "R9", "reset serial outputs",
          64'({fcs_valid, fcs_bit}), 64'd0);
      chk(done === 1'b0 && err_valid === 1'b0 && crc_err === 1'b0, "R9", "reset flags",
          64'({done, err_valid, crc_err}), 64'd0);
   endtask

   task automatic t_idle_ignore();
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (fcs_valid !== 1'b0 || done !== 1'b0 || err_valid !== 1'b0) quiet = 1'b0;
         bit_valid = 1'b1; bit_in = i[0]; data_end = i[1]; mode_sel = i[2];
      end
      @(negedge clk);
      if (fcs_valid !== 1'b0 || done !== 1'b0 || err_valid !== 1'b0) quiet = 1'b0;
      idle_inputs();
      @(negedge clk);
      if (fcs_valid !== 1'b0 || done !== 1'b0 || err_valid !== 1'b0) quiet = 1'b0;
      chk(quiet, "R7", "no output activity without a frame", 64'(quiet), 64'd1);
   endtask

   task automatic t_restart();
      logic [31:0] got;
      open_frame(3'd4, 1'b0, 1'b0);
      feed(160'h5A5A, 16, 1'b0);
      // The frame above ended; now open one, abandon it mid-way, then restart
      open_frame(3'd2, 1'b1, 1'b0);
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         sof = 1'b0; bit_valid = 1'b1; bit_in = 1'b1; data_end = 1'b0;
      end
      run_gen(3'd1, 128'hB3C, 12, 1'b0, 1'b0, 1'b0, "R10 restart", got);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] got;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      // R1, R5: every polynomial code including the aliases
      run_gen(3'd0, 128'h2D1, 10, 1'b0, 1'b0, 1'b0, "R1 test poly", got);
      run_gen(3'd1, 128'hC0FFEE, 24, 1'b0, 1'b0, 1'b0, "R1 deg12", got);
      run_gen(3'd2, 128'h1234_5678, 32, 1'b0, 1'b0, 1'b0, "R1 deg16a", got);
      run_gen(3'd3, 128'h8000_0001, 32, 1'b0, 1'b0, 1'b0, "R1 deg16b", got);
      run_gen(3'd4, 128'hDEAD_BEEF_0BAD_F00D, 64, 1'b0, 1'b0, 1'b0, "R1 deg32", got);
      run_gen(3'd6, 128'h2D1, 10, 1'b0, 1'b0, 1'b0, "R1 alias code 6", got);
      run_gen(3'd0, 128'h1, 1, 1'b0, 1'b0, 1'b0, "R5 single bit", got);
      run_gen(3'd4, 128'h0, 8, 1'b0, 1'b0, 1'b0, "R5 zero message", got);

      // R5: published value for the nine-digit ASCII string
      run_gen(3'd3, 128'h31_3233_3435_3637_3839, 72, 1'b0, 1'b0, 1'b0, "R5 ascii", got);
      chk(got[15:0] == 16'h31C3, "R5", "known ascii remainder", 64'(got), 64'h31C3);

      // R2: bit offered with sof is not consumed
      run_gen(3'd2, 128'hA5, 8, 1'b1, 1'b0, 1'b0, "R2 bit with sof", got);
      // R8: selects changed mid-frame
      run_gen(3'd1, 128'h3C96, 16, 1'b0, 1'b1, 1'b0, "R8 select change", got);
      // R7: input activity while shifting out
      run_gen(3'd3, 128'h7E01, 16, 1'b0, 1'b0, 1'b1, "R7 shift disturb", got);
      t_idle_ignore();
      t_restart();

      // R6: clean and corrupted received frames
      run_chk(3'd0, 128'h2D1, 10, 160'h0, "R6 clean test poly");
      run_chk(3'd4, 128'hDEAD_BEEF, 32, 160'h0, "R6 clean deg32");
      run_chk(3'd2, 128'h1234, 16, 160'h400, "R6 single flip");
      run_chk(3'd3, 128'hFACE, 16, 160'h3F0, "R6 burst");
      run_chk(3'd1, 128'h5A5, 12, 160'h1, "R6 flip in fcs");
      run_chk(3'd7, 128'hF0, 8, 160'h0, "R6 alias clean");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule